// File: doc/BRIEF.md
# Packet Receive Buffer with Data-Available Flag

This block is a single-clock first-in first-out buffer placed between a link receiver and user logic. Every stored word carries its data together with sideband fields: a start-of-packet marker, an end-of-packet marker, a per-word error marker, a count of unused bytes in the word, and a packet identifier. The receiver pushes words with a valid strobe. User logic pulls them with a read enable and sees the word one cycle later, qualified by a valid output.

User logic decides when to start draining by watching a data-available flag. The flag rises when the stored word count exceeds a low-water threshold. When the packet-end option is on, the flag also rises while at least one complete packet end sits in the buffer. This lets short packets leave without waiting for the threshold to fill. The threshold and the option are captured while reset is held and are frozen afterwards.

The block also reports two status conditions. An empty level shows when nothing is stored. A one-cycle overflow pulse marks a word that was dropped because the buffer was full.

Top module: `pkt_rx_buffer`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `empty` is 1 and `data_avail`, `rd_valid` and `overflow` are 0.
- R2: Words leave in the order they were written, and data, `rd_sop`, `rd_eop`, `rd_err` and `rd_mty` are returned unchanged. The unused-byte field is log2(DATA_W/8) bits wide (2 bits at the default width of 32).
- R3: A read enable sampled at a clock edge while the buffer holds at least one word makes `rd_valid` high after that edge, with the oldest word on the outputs. In every other cycle `rd_valid` is 0.
- R4: A read enable while the buffer is empty is ignored: `rd_valid` stays 0 and the next word written is the next word read.
- R5: With the packet-end option off, `data_avail` is 1 exactly when the stored word count is strictly greater than the captured threshold.
- R6: With the packet-end option on, `data_avail` is also 1 while at least one stored word has its end-of-packet marker set. It falls once the last such word has been read, unless the count is above the threshold.
- R7: A write while the buffer holds DEPTH words is dropped, even if a read happens in the same cycle. `overflow` is 1 for exactly the cycle after that edge, and the stored words are unaffected.
- R8: `thresh_lo` and `eop_avail_en` are captured only on clock edges where `rst` is high. Changing them afterwards has no effect on `data_avail`.
- R9: `rd_id` carries the stored identifier only when `rd_valid` and `rd_sop` are both 1 and is 0 otherwise. `rd_err` is reported per word and is not stretched to the end of the packet.
- R10: `empty` is 1 exactly when no words are stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; also captures the configuration |
| thresh_lo | input | $clog2(DEPTH)+1 | Low-water threshold in words |
| eop_avail_en | input | 1 | Enables raising `data_avail` on a stored packet end |
| wr_valid | input | 1 | Write strobe |
| wr_data | input | DATA_W | Write data |
| wr_sop | input | 1 | Start-of-packet marker of the written word |
| wr_eop | input | 1 | End-of-packet marker of the written word |
| wr_err | input | 1 | Error marker of the written word |
| wr_mty | input | log2(DATA_W/8) | Unused byte count of the written word |
| wr_id | input | ID_W | Packet identifier of the written word |
| rd_en | input | 1 | Read request |
| rd_valid | output | 1 | Read outputs hold a word this cycle |
| rd_data | output | DATA_W | Read data |
| rd_sop | output | 1 | Start-of-packet marker of the read word |
| rd_eop | output | 1 | End-of-packet marker of the read word |
| rd_err | output | 1 | Error marker of the read word |
| rd_mty | output | log2(DATA_W/8) | Unused byte count of the read word |
| rd_id | output | ID_W | Packet identifier, nonzero only with start-of-packet |
| data_avail | output | 1 | Data-available flag |
| empty | output | 1 | No word stored |
| overflow | output | 1 | One-cycle pulse after a dropped write |

## Verification
The assertions assume that `rst` is held for at least one clock edge before use, so that the captured threshold and option are defined. They also assume that the write strobe and read enable are never unknown outside reset. The bench drives every input to a known value before the first edge. It only changes `thresh_lo` and `eop_avail_en` outside reset when the aim is to show that such changes are ignored. All stimulus changes one time unit after a rising edge, well away from the sampling edge.

// File: rtl/pkt_rx_buffer.sv
module pkt_rx_buffer #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8,
  parameter int ID_W   = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [$clog2(DEPTH):0]      thresh_lo,
  input  logic                        eop_avail_en,
  input  logic                        wr_valid,
  input  logic [DATA_W-1:0]           wr_data,
  input  logic                        wr_sop,
  input  logic                        wr_eop,
  input  logic                        wr_err,
  input  logic [$clog2(DATA_W/8)-1:0] wr_mty,
  input  logic [ID_W-1:0]             wr_id,
  input  logic                        rd_en,
  output logic                        rd_valid,
  output logic [DATA_W-1:0]           rd_data,
  output logic                        rd_sop,
  output logic                        rd_eop,
  output logic                        rd_err,
  output logic [$clog2(DATA_W/8)-1:0] rd_mty,
  output logic [ID_W-1:0]             rd_id,
  output logic                        data_avail,
  output logic                        empty,
  output logic                        overflow
);
  localparam int MTY_W = $clog2(DATA_W/8);
  localparam int AW    = $clog2(DEPTH);
  localparam int CW    = AW + 1;
  localparam int EW    = DATA_W + 3 + MTY_W + ID_W;
  localparam int B_SOP = DATA_W;
  localparam int B_EOP = DATA_W + 1;
  localparam int B_ERR = DATA_W + 2;
  localparam int B_MTY = DATA_W + 3;
  localparam int B_ID  = DATA_W + 3 + MTY_W;
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [EW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count, eop_cnt, thr_q;
  logic          eop_en_q;
  logic [EW-1:0] out_q;
  logic          full, wr_ok, rd_ok, head_eop;

  assign full     = (count == FULL_CNT);
  assign empty    = (count == '0);
  assign wr_ok    = wr_valid && !full;
  assign rd_ok    = rd_en && !empty;
  assign head_eop = mem[rd_ptr][B_EOP];

  always_ff @(posedge clk) begin
    if (rst) begin
      thr_q    <= thresh_lo;
      eop_en_q <= eop_avail_en;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wr_ptr] <= {wr_id, wr_mty, wr_err, wr_eop, wr_sop, wr_data};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      count    <= '0;
      eop_cnt  <= '0;
      rd_valid <= 1'b0;
      overflow <= 1'b0;
      out_q    <= '0;
    end else begin
      if (wr_ok) wr_ptr <= wr_ptr + 1'b1;
      if (rd_ok) begin
        rd_ptr <= rd_ptr + 1'b1;
        out_q  <= mem[rd_ptr];
      end
      count    <= count + CW'(wr_ok) - CW'(rd_ok);
      eop_cnt  <= eop_cnt + CW'(wr_ok && wr_eop) - CW'(rd_ok && head_eop);
      rd_valid <= rd_ok;
      overflow <= wr_valid && full;
    end
  end

  assign data_avail = (count > thr_q) || (eop_en_q && eop_cnt != '0);

  assign rd_data = out_q[DATA_W-1:0];
  assign rd_sop  = rd_valid && out_q[B_SOP];
  assign rd_eop  = rd_valid && out_q[B_EOP];
  assign rd_err  = rd_valid && out_q[B_ERR];
  assign rd_mty  = rd_valid ? out_q[B_MTY +: MTY_W] : '0;
  assign rd_id   = (rd_valid && out_q[B_SOP]) ? out_q[B_ID +: ID_W] : '0;

  assert_full_drop_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && full) |=> overflow);

  assert_no_spurious_ovf_R7: assert property (@(posedge clk) disable iff (rst)
    !(wr_valid && full) |=> !overflow);

  assert_read_latency_R3: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !empty) |=> rd_valid);

  assert_empty_read_R4: assert property (@(posedge clk) disable iff (rst)
    (!rd_en || empty) |=> !rd_valid);

  assert_idle_no_avail_R6: assert property (@(posedge clk) disable iff (rst)
    empty |-> !data_avail);

  assert_eop_bound_R6: assert property (@(posedge clk) disable iff (rst)
    eop_cnt <= count);

  assert_cfg_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ($stable(thr_q) && $stable(eop_en_q)));
endmodule

// File: tb/pkt_rx_buffer_test.sv
module pkt_rx_buffer_test;
  localparam int DATA_W = 32;
  localparam int DEPTH  = 8;
  localparam int ID_W   = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst = 1'b1;
  logic [3:0]  thresh_lo = 4'd3;
  logic        eop_avail_en = 1'b0;
  logic        wr_valid = 1'b0, wr_sop = 1'b0, wr_eop = 1'b0, wr_err = 1'b0;
  logic [31:0] wr_data = '0;
  logic [1:0]  wr_mty = '0;
  logic [7:0]  wr_id = '0;
  logic        rd_en = 1'b0;
  logic        rd_valid, rd_sop, rd_eop, rd_err, data_avail, empty, overflow;
  logic [31:0] rd_data;
  logic [1:0]  rd_mty;
  logic [7:0]  rd_id;

  pkt_rx_buffer #(.DATA_W(DATA_W), .DEPTH(DEPTH), .ID_W(ID_W)) uut (
    .clk(clk), .rst(rst), .thresh_lo(thresh_lo), .eop_avail_en(eop_avail_en),
    .wr_valid(wr_valid), .wr_data(wr_data), .wr_sop(wr_sop), .wr_eop(wr_eop),
    .wr_err(wr_err), .wr_mty(wr_mty), .wr_id(wr_id), .rd_en(rd_en),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_sop(rd_sop), .rd_eop(rd_eop),
    .rd_err(rd_err), .rd_mty(rd_mty), .rd_id(rd_id), .data_avail(data_avail),
    .empty(empty), .overflow(overflow));

  // {data[44:13], sop[12], eop[11], err[10], mty[9:8], id[7:0]}
  localparam logic [44:0] VEC [5] = '{
    {32'hA0000001, 1'b1, 1'b0, 1'b0, 2'd0, 8'h21},
    {32'hA0000002, 1'b0, 1'b0, 1'b0, 2'd0, 8'h55},
    {32'hA0000003, 1'b0, 1'b1, 1'b0, 2'd3, 8'h00},
    {32'hB0000001, 1'b1, 1'b0, 1'b1, 2'd0, 8'h3C},
    {32'hB0000002, 1'b0, 1'b1, 1'b0, 2'd1, 8'h77}
  };

  int tests = 0, fails = 0;
  bit done = 1'b0;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic put(input logic [31:0] d, input logic s, input logic e);
    wr_valid = 1'b1; wr_data = d; wr_sop = s; wr_eop = e;
    wr_err = 1'b0; wr_mty = 2'd0; wr_id = 8'h0;
    step();
    wr_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    step(); step();
    check("R1 empty in reset", empty, 1);
    check("R1 rd_valid in reset", rd_valid, 0);
    rst = 1'b0;
    step();
    check("R1 empty after reset", empty, 1);
    check("R1 data_avail after reset", data_avail, 0);
    check("R1 overflow after reset", overflow, 0);

    for (int i = 0; i < 5; i++) begin
      wr_valid = 1'b1;
      {wr_data, wr_sop, wr_eop, wr_err, wr_mty, wr_id} = VEC[i];
      step();
      check("R5 threshold compare", data_avail, (i + 1) > 3);
      check("R10 not empty after write", empty, 0);
    end
    wr_valid = 1'b0;

    rd_en = 1'b1;
    for (int i = 0; i < 5; i++) begin
      step();
      check("R3 rd_valid after enable", rd_valid, 1);
      check("R2 data order", rd_data, VEC[i][44:13]);
      check("R2 sop", rd_sop, VEC[i][12]);
      check("R2 eop", rd_eop, VEC[i][11]);
      check("R9 per-word err", rd_err, VEC[i][10]);
      check("R2 mty", rd_mty, VEC[i][9:8]);
      check("R9 id only with sop", rd_id, VEC[i][12] ? VEC[i][7:0] : 8'h0);
    end
    check("R10 empty after drain", empty, 1);
    step();
    check("R4 read on empty ignored", rd_valid, 0);
    rd_en = 1'b0;
    step();
    check("R3 no valid without enable", rd_valid, 0);
    put(32'hC0FFEE00, 1'b1, 1'b1);
    rd_en = 1'b1; step(); rd_en = 1'b0;
    check("R4 pointer unmoved by empty read", rd_data, 32'hC0FFEE00);

    for (int k = 0; k < 8; k++) begin
      put(32'h100 + 32'(k), 1'b0, 1'b0);
      check("R7 no overflow while filling", overflow, 0);
    end
    check("R5 full above threshold", data_avail, 1);
    wr_valid = 1'b1; wr_data = 32'hDEAD; rd_en = 1'b1;
    step();
    wr_valid = 1'b0; rd_en = 1'b0;
    check("R7 overflow pulse", overflow, 1);
    check("R3 read during drop", rd_data, 32'h100);
    step();
    check("R7 overflow one cycle", overflow, 0);
    rd_en = 1'b1;
    for (int k = 1; k < 8; k++) begin
      step();
      check("R7 contents intact", rd_data, 32'h100 + 32'(k));
    end
    step();
    rd_en = 1'b0;
    check("R7 dropped word absent", rd_valid, 0);

    thresh_lo = 4'd0;
    put(32'h77, 1'b0, 1'b0);
    check("R8 threshold change ignored", data_avail, 0);
    rd_en = 1'b1; step(); rd_en = 1'b0;

    rst = 1'b1; thresh_lo = 4'd5; eop_avail_en = 1'b1;
    step(); step();
    rst = 1'b0; thresh_lo = 4'd0; eop_avail_en = 1'b0;
    step();
    put(32'h1, 1'b1, 1'b0);
    check("R6 no eop stored", data_avail, 0);
    put(32'h2, 1'b0, 1'b1);
    check("R6 eop below threshold", data_avail, 1);
    rd_en = 1'b1;
    step();
    check("R6 eop still stored", data_avail, 1);
    step();
    rd_en = 1'b0;
    check("R6 eop word read", rd_eop, 1);
    check("R6 flag drops after eop read", data_avail, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule